// File: doc/BRIEF.md
# Dual Wiper Position Register Bank with Tap Decoder

This block keeps the wiper position of each potentiometer in a bank of resistor-ladder controls. Each potentiometer has one volatile 6-bit position counter and four stored preset registers. A command decoder upstream presents one command per cycle. The bank carries out each command in that cycle: a direct load of the position, a preset write, a copy between a preset and the position (for one potentiometer, or for all of them at once), a single-tap step up or down, or a read-back. Each position counter drives a registered one-hot switch-enable vector, so exactly one tap switch of each ladder is closed at all times.

A separate restore pulse reloads every position counter from its own preset 0. This is the recovery used at power-up. The pulse is separate from the logic reset, which clears everything.

Commands flow in on a valid-qualified strobe and read data flows out on a valid-qualified strobe. The block accepts a command on every cycle that `cmd_valid` is high. It has no ready signal and applies no back-pressure. A read result is presented for exactly one cycle and cannot be stalled, so the consumer must capture it in that cycle.

Top module: `wiper_bank`

## Requirements
- R1: After `rst_n` is released, every position counter and every preset register is 0, each tap vector has only bit 0 set, `rd_valid` is 0 and `rd_data` is 0.
- R2: Op 1 (load position) with `cmd_valid` high sets the position counter of pot `cmd_pot` to `cmd_wdata`. The other pot is unchanged.
- R3: Op 2 (write preset) stores `cmd_wdata` into preset `cmd_reg` of pot `cmd_pot`. Op 4 (read preset) then returns that value zero-extended to 8 bits.
- R4: Op 3 (read position) and op 4 (read preset) raise `rd_valid` for exactly the one cycle after the command edge, with the value zero-extended. While `rd_valid` is low, `rd_data` is 0.
- R5: Op 5 copies preset `cmd_reg` of pot `cmd_pot` into that pot's position counter.
- R6: Op 6 copies the position counter of pot `cmd_pot` into its preset `cmd_reg`.
- R7: Op 7 copies preset `cmd_reg` into the position counter of every pot at once, and ignores `cmd_pot`.
- R8: Op 8 copies every pot's position counter into that pot's preset `cmd_reg` at once, and ignores `cmd_pot`.
- R9: Op 9 moves the selected position one tap toward the high end (+1) and holds at 63.
- R10: Op 10 moves the selected position one tap toward the low end (-1) and holds at 0.
- R11: A cycle with `por` high loads every position counter from its own preset 0. Any command presented in that same cycle is discarded, and no read result is produced.
- R12: Tap vector of pot i (`tap_onehot[64*i +: 64]`) equals 1 shifted left by that pot's position, one cycle after the position changes, and always has exactly one bit set.
- R13: A command with `cmd_valid` low, or with an op code of 0 or 11 to 15, changes no register and produces no read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por | input | 1 | Restore pulse: reload positions from preset 0 |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Operation code (see requirements) |
| cmd_pot | input | 1 | Potentiometer select |
| cmd_reg | input | 2 | Preset register select |
| cmd_wdata | input | 6 | Write data for loads and preset writes |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 8 | Read result, zero-extended |
| tap_onehot | output | 128 | One-hot switch enables, 64 per pot, pot 0 in the low bits |

## Verification
The hardest states to reach from the ports are the saturation edges at codes 0 and 63. Random loads seldom land next to them, so directed sequences load 61 and 2 and step past each limit. A restore pulse that coincides with a valid command is equally rare. The stimulus forces that overlap directly and also raises `por` now and then during the random phase, while the presets hold unequal values, so a restore can be told apart from a plain reset.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LDW  = 4'd1,
    OP_WRP  = 4'd2,
    OP_RDW  = 4'd3,
    OP_RDP  = 4'd4,
    OP_P2W  = 4'd5,
    OP_W2P  = 4'd6,
    OP_GP2W = 4'd7,
    OP_GW2P = 4'd8,
    OP_UP   = 4'd9,
    OP_DN   = 4'd10
  } wb_op_e;
endpackage

// File: rtl/wb_pot_regs.sv
module wb_pot_regs
  import wb_pkg::*;
#(
  parameter int WBITS = 6,
  parameter int NDR   = 4,
  localparam int REG_W = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por,
  input  logic             hit,
  input  logic [3:0]       op,
  input  logic [REG_W-1:0] reg_sel,
  input  logic [WBITS-1:0] wdata,
  output logic [WBITS-1:0] pos_q,
  output logic [WBITS-1:0] preset_q
);
  localparam logic [WBITS-1:0] TOP = {WBITS{1'b1}};

  logic [WBITS-1:0] preset [NDR];

  assign preset_q = preset[reg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      for (int k = 0; k < NDR; k++) preset[k] <= '0;
    end else if (por) begin
      pos_q <= preset[0];
    end else if (hit) begin
      case (op)
        OP_LDW:           pos_q <= wdata;
        OP_WRP:           preset[reg_sel] <= wdata;
        OP_P2W, OP_GP2W:  pos_q <= preset[reg_sel];
        OP_W2P, OP_GW2P:  preset[reg_sel] <= pos_q;
        OP_UP:            if (pos_q != TOP) pos_q <= pos_q + 1'b1;
        OP_DN:            if (pos_q != '0) pos_q <= pos_q - 1'b1;
        default:          ;
      endcase
    end
  end

  assert_sat_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !por && op == OP_UP && pos_q == TOP) |=> pos_q == TOP);
  assert_step_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !por && op == OP_UP && pos_q != TOP) |=> pos_q == $past(pos_q) + 1'b1);
  assert_sat_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !por && op == OP_DN && pos_q == '0) |=> pos_q == '0);
  assert_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> pos_q == $past(preset[0]));
  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !por) |=> $stable(pos_q));
endmodule

// File: rtl/wb_tap_dec.sv
module wb_tap_dec #(
  parameter int WBITS = 6,
  localparam int TAPS = 1 << WBITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WBITS-1:0] pos,
  output logic [TAPS-1:0]  tap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= TAPS'(1);
    else        tap_q <= TAPS'(1) << pos;
  end

  assert_single_tap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_q) == 1);
  assert_tap_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pos) |=> $stable(tap_q));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wb_pkg::*;
#(
  parameter int NPOT  = 2,
  parameter int WBITS = 6,
  parameter int NDR   = 4,
  parameter int RDW   = 8,
  localparam int TAPS  = 1 << WBITS,
  localparam int POT_W = (NPOT > 1) ? $clog2(NPOT) : 1,
  localparam int REG_W = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por,
  input  logic                 cmd_valid,
  input  logic [3:0]           cmd_op,
  input  logic [POT_W-1:0]     cmd_pot,
  input  logic [REG_W-1:0]     cmd_reg,
  input  logic [WBITS-1:0]     cmd_wdata,
  output logic                 rd_valid,
  output logic [RDW-1:0]       rd_data,
  output logic [NPOT*TAPS-1:0] tap_onehot
);
  logic             live, is_glob, is_rd;
  logic [WBITS-1:0] pos_a    [NPOT];
  logic [WBITS-1:0] preset_a [NPOT];
  logic [WBITS-1:0] rd_src;

  assign live    = cmd_valid && !por;
  assign is_glob = (cmd_op == OP_GP2W) || (cmd_op == OP_GW2P);
  assign is_rd   = (cmd_op == OP_RDW) || (cmd_op == OP_RDP);

  for (genvar g = 0; g < NPOT; g++) begin : g_pot
    logic hit;
    assign hit = live && (is_glob || cmd_pot == POT_W'(g));

    wb_pot_regs #(.WBITS(WBITS), .NDR(NDR)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .por      (por),
      .hit      (hit),
      .op       (cmd_op),
      .reg_sel  (cmd_reg),
      .wdata    (cmd_wdata),
      .pos_q    (pos_a[g]),
      .preset_q (preset_a[g])
    );

    wb_tap_dec #(.WBITS(WBITS)) u_tap (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (pos_a[g]),
      .tap_q (tap_onehot[g*TAPS +: TAPS])
    );
  end

  always_comb begin
    rd_src = '0;
    for (int i = 0; i < NPOT; i++)
      if (cmd_pot == POT_W'(i))
        rd_src = (cmd_op == OP_RDW) ? pos_a[i] : preset_a[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (live && is_rd) begin
      rd_valid <= 1'b1;
      rd_data  <= RDW'(rd_src);
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end

  assert_rd_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !por && (cmd_op == OP_RDW || cmd_op == OP_RDP)));
  assert_rd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !(live && is_rd)) |=> !rd_valid);
  assert_por_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> !rd_valid);
endmodule

// File: tb/wiper_bank_bench.sv
module wiper_bank_bench;
  logic         clk = 1'b0;
  logic         rst_n, por, cmd_valid;
  logic [3:0]   cmd_op;
  logic [0:0]   cmd_pot;
  logic [1:0]   cmd_reg;
  logic [5:0]   cmd_wdata;
  logic         rd_valid;
  logic [7:0]   rd_data;
  logic [127:0] tap_onehot;

  always #4 clk = ~clk;

  wiper_bank u_wiper_bank (
    .clk(clk), .rst_n(rst_n), .por(por), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_pot(cmd_pot), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .tap_onehot(tap_onehot)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [5:0] m_pos [2];
  logic [5:0] m_pre [2][4];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] onehot(logic [5:0] v);
    return 64'd1 << v;
  endfunction

  function automatic string tag_of(logic [3:0] op, logic pr, logic v);
    if (pr) return "R11";
    if (!v || op == 0 || op > 10) return "R13";
    case (op)
      1: return "R2";  2: return "R3";  3: return "R4";  4: return "R3";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic cmd(logic v, logic [3:0] op, logic p, logic [1:0] r,
                     logic [5:0] d, logic pr, string req);
    logic       is_rd;
    logic [7:0] exp_rd;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_pot = p; cmd_reg = r;
    cmd_wdata = d; por = pr;
    is_rd  = v && !pr && (op == 3 || op == 4);
    exp_rd = !is_rd ? 8'd0 : (op == 3) ? {2'b0, m_pos[p]} : {2'b0, m_pre[p][r]};
    if (pr) begin
      for (int i = 0; i < 2; i++) m_pos[i] = m_pre[i][0];
    end else if (v) begin
      case (op)
        1: m_pos[p] = d;
        2: m_pre[p][r] = d;
        5: m_pos[p] = m_pre[p][r];
        6: m_pre[p][r] = m_pos[p];
        7: for (int i = 0; i < 2; i++) m_pos[i] = m_pre[i][r];
        8: for (int i = 0; i < 2; i++) m_pre[i][r] = m_pos[i];
        9: if (m_pos[p] != 6'd63) m_pos[p] = m_pos[p] + 6'd1;
        10: if (m_pos[p] != 6'd0) m_pos[p] = m_pos[p] - 6'd1;
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b0; por = 1'b0;
    chk({req, " rd_valid"}, 64'(rd_valid), 64'(is_rd));
    chk({req, " rd_data"}, 64'(rd_data), 64'(exp_rd));
    @(negedge clk);
    chk({req, " rd_valid drop"}, 64'(rd_valid), 64'd0);
    chk({req, " tap0"}, tap_onehot[63:0], onehot(m_pos[0]));
    chk({req, " tap1"}, tap_onehot[127:64], onehot(m_pos[1]));
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; por = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
    cmd_pot = '0; cmd_reg = '0; cmd_wdata = '0;
    for (int i = 0; i < 2; i++) begin
      m_pos[i] = '0;
      for (int k = 0; k < 4; k++) m_pre[i][k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 rd_data", 64'(rd_data), 64'd0);
    chk("R1 tap0", tap_onehot[63:0], 64'd1);
    chk("R1 tap1", tap_onehot[127:64], 64'd1);
    for (int k = 0; k < 4; k++) cmd(1, 4, 1, 2'(k), 0, 0, "R1");

    cmd(1, 1, 0, 0, 37, 0, "R2");
    cmd(1, 1, 1, 0, 5, 0, "R2");
    cmd(1, 2, 1, 2, 50, 0, "R3");
    cmd(1, 4, 1, 2, 0, 0, "R3");
    cmd(1, 3, 0, 0, 0, 0, "R4");
    cmd(1, 2, 0, 3, 12, 0, "R5");
    cmd(1, 5, 0, 3, 0, 0, "R5");
    cmd(1, 6, 1, 1, 0, 0, "R6");
    cmd(1, 4, 1, 1, 0, 0, "R6");
    cmd(1, 2, 0, 2, 44, 0, "R7");
    cmd(1, 7, 0, 2, 0, 0, "R7");
    cmd(1, 1, 0, 0, 9, 0, "R8");
    cmd(1, 8, 1, 0, 0, 0, "R8");
    cmd(1, 4, 0, 0, 0, 0, "R8");
    cmd(1, 4, 1, 0, 0, 0, "R8");
    cmd(1, 1, 1, 0, 61, 0, "R9");
    for (int s = 0; s < 4; s++) cmd(1, 9, 1, 0, 0, 0, "R9");
    cmd(1, 1, 0, 0, 2, 0, "R10");
    for (int s = 0; s < 4; s++) cmd(1, 10, 0, 0, 0, 0, "R10");
    cmd(1, 2, 0, 0, 21, 0, "R11");
    cmd(1, 2, 1, 0, 58, 0, "R11");
    cmd(1, 1, 0, 0, 3, 1, "R11");
    cmd(1, 3, 1, 0, 0, 1, "R11");
    cmd(1, 3, 0, 0, 0, 0, "R11");
    cmd(0, 1, 0, 0, 33, 0, "R13");
    cmd(0, 3, 0, 0, 0, 0, "R13");
    for (int o = 11; o < 16; o++) cmd(1, 4'(o), 1, 1, 7, 0, "R13");
    cmd(1, 0, 0, 0, 7, 0, "R13");
    cmd(1, 4, 1, 1, 0, 0, "R13");

    for (int n = 0; n < 600; n++) begin
      logic [3:0] op;
      logic v, pr;
      op = 4'($urandom_range(0, 15));
      v  = ($urandom_range(0, 9) != 0);
      pr = ($urandom_range(0, 39) == 0);
      cmd(v, op, 1'($urandom), 2'($urandom), 6'($urandom), pr, tag_of(op, pr, v));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule